// File: doc/BRIEF.md
# Random-Except-MRU Victim Selector

This block chooses which way of a cache set is evicted when a new block must be brought in. It serves an N-way set-associative cache (a fully associative cache is the case of a single set). For every set it keeps one small register naming the way that was touched most recently. A hit, or the completion of a fill, rewrites that register. On a miss the block returns a victim way one cycle later. That way is chosen pseudo-randomly, but it is never the way that was used most recently. This costs far less state than a full least-recently-used ordering.

If the set still holds an empty way, the selector takes that way before any random choice. The random draw comes from an internal free-running linear feedback shift register. When the draw lands on the recorded most-recently-used way, the selector takes the next way up instead, with wrap-around. The decision is made in a single cycle and its result is registered. The tag arrays, the data arrays and the cache controller sit outside this block. The controller supplies the valid bits of the addressed set together with each request.

Top module: `victim_picker`

## Requirements
- R1: After a synchronous active-low reset, `victim_vld` is 0, `victim_way` is 0, and the recorded most-recently-used way of every set is 0.
- R2: A request with `req_vld`=1 and `req_hit`=1 sets the recorded most-recently-used way of set `req_set` to `req_way`, taking effect at the next clock edge.
- R3: `fill_vld`=1 sets the recorded most-recently-used way of set `fill_set` to `fill_way`. If a hit to the same set occurs in the same cycle, the hit way is the one recorded.
- R4: A miss is a request with `req_vld`=1 and `req_hit`=0. `victim_vld` is 1 in exactly the cycle after each miss and 0 otherwise. `victim_way` keeps its value in every cycle that does not follow a miss.
- R5: If any bit of `way_valid` (bit i stands for way i, where 1 means valid) is 0 at the miss, the victim is the lowest-numbered way whose bit is 0.
- R6: If all ways are valid, the draw is the low log2(WAYS) bits of the shift register at the miss edge. If the draw equals the recorded most-recently-used way of `req_set`, the victim is that way plus one, modulo WAYS. The victim therefore never equals the recorded way. The recorded way used is the value held before any update in the same cycle.
- R7: The shift register is 16 bits wide and loads 0xACE1 during reset. It steps on every clock edge with reset released, to {s[14:0], s[15]^s[13]^s[12]^s[10]}. It is never zero.
- R8: With WAYS=2 and both ways valid, the victim is always the way that is not the recorded most-recently-used way.
- R9: WAYS is a power of two from 2 to 16 and SETS is a power of two of at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_vld | input | 1 | Lookup result is present this cycle |
| req_hit | input | 1 | 1 = the lookup hit, 0 = the lookup missed and needs a victim |
| req_set | input | log2(SETS) | Set addressed by the lookup |
| req_way | input | log2(WAYS) | Way that hit (ignored on a miss) |
| way_valid | input | WAYS | Valid bits of the addressed set's ways |
| fill_vld | input | 1 | A fill has completed |
| fill_set | input | log2(SETS) | Set that was filled |
| fill_way | input | log2(WAYS) | Way that was filled |
| victim_way | output | log2(WAYS) | Chosen victim way |
| victim_vld | output | 1 | Victim is valid, one cycle after a miss |

## Verification
The bench builds two copies side by side, both with eight sets. One has four ways, where the wrap from way 3 to way 0 and every collision between the draw and the recorded way can occur. The other has two ways, where the victim is forced to the single non-recent way. Both copies see the same stream of hits, fills, collisions of a hit and a fill, and partly empty sets. A behavioural model tracks the recorded ways and the shift register value for each copy and predicts the victim on every cycle.

// File: rtl/rp_pkg.sv
// Shared constants and helpers for the victim selector.
// Assumes a 16-bit Fibonacci shift register with taps at bits 15,13,12,10.
package rp_pkg;
    localparam int          RND_W    = 16;
    localparam logic [15:0] RND_SEED = 16'hACE1;

    // Next state of the maximal-length shift register.
    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        return {s[RND_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/rp_lfsr.sv
// Free-running pseudo-random source.
// Loads SEED during reset and advances once per clock afterwards.
// Assumes SEED is nonzero, so the register never reaches the all-zero lock state.
module rp_lfsr
    import rp_pkg::*;
#(
    parameter logic [RND_W-1:0] SEED = RND_SEED
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [RND_W-1:0] rnd_q
);
    // Step the register every cycle once reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) rnd_q <= SEED;
        else        rnd_q <= rnd_step(rnd_q);
    end
endmodule

// File: rtl/rp_mru_table.sv
// Per-set store of the most recently used way, log2(WAYS) bits per set.
// A hit write overrides a fill write that targets the same set in the same cycle.
// The read port is combinational and returns the value held before this cycle's writes.
module rp_mru_table #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_we,
    input  logic [SET_W-1:0] hit_set,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_we,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] rd_mru
);
    logic [WAY_W-1:0] mru_q [SETS];

    // Record the newest way per set; the hit takes priority over the fill.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (!rst_n)
                mru_q[s] <= '0;
            else if (hit_we && hit_set == SET_W'(s))
                mru_q[s] <= hit_way;
            else if (fill_we && fill_set == SET_W'(s))
                mru_q[s] <= fill_way;
        end
    end

    // Read the stored way of the set under lookup.
    always_comb rd_mru = mru_q[rd_set];
endmodule

// File: rtl/rp_pick.sv
// Combinational victim choice for one set.
// An empty way wins first, lowest index first. Otherwise the random draw is
// used, moved one way up (with wrap) when it hits the recorded MRU way.
// For two ways the full-set choice collapses to the inverse of the MRU way.
module rp_pick #(
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    input  logic [WAY_W-1:0] mru,
    input  logic [WAY_W-1:0] draw,
    output logic [WAY_W-1:0] victim
);
    logic [WAY_W-1:0] full_pick;
    logic [WAY_W-1:0] empty_pick;
    logic             has_empty;

    generate
        if (WAYS == 2) begin : g_two
            // Only one way differs from the MRU way.
            always_comb full_pick = ~mru;
        end else begin : g_many
            // Take the draw unless it collides; then step past the MRU way.
            always_comb full_pick = (draw == mru) ? mru + WAY_W'(1) : draw;
        end
    endgenerate

    // Find the lowest-numbered empty way.
    always_comb begin
        empty_pick = '0;
        has_empty  = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) begin
                empty_pick = WAY_W'(i);
                has_empty  = 1'b1;
            end
        end
    end

    // An empty way beats any random choice.
    always_comb victim = has_empty ? empty_pick : full_pick;
endmodule

// File: rtl/victim_picker.sv
// Replacement victim selector: random choice that excludes the per-set MRU way.
// Assumes the controller presents the addressed set's valid bits with each
// request, and that at most one lookup and one fill arrive per cycle.
// The victim is registered and is presented one cycle after the miss.
module victim_picker
    import rp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  logic             req_hit,
    input  logic [SET_W-1:0] req_set,
    input  logic [WAY_W-1:0] req_way,
    input  logic [WAYS-1:0]  way_valid,
    input  logic             fill_vld,
    input  logic [SET_W-1:0] fill_set,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_vld
);
    logic [RND_W-1:0] lfsr_q;
    logic [WAY_W-1:0] mru_rd;
    logic [WAY_W-1:0] pick;
    logic             miss;

    // A lookup that did not hit needs a victim.
    always_comb miss = req_vld && !req_hit;

    rp_lfsr #(.SEED(RND_SEED)) u_rnd (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_q (lfsr_q)
    );

    rp_mru_table #(.WAYS(WAYS), .SETS(SETS)) u_mru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_we   (req_vld && req_hit),
        .hit_set  (req_set),
        .hit_way  (req_way),
        .fill_we  (fill_vld),
        .fill_set (fill_set),
        .fill_way (fill_way),
        .rd_set   (req_set),
        .rd_mru   (mru_rd)
    );

    rp_pick #(.WAYS(WAYS)) u_pick (
        .way_valid (way_valid),
        .mru       (mru_rd),
        .draw      (lfsr_q[WAY_W-1:0]),
        .victim    (pick)
    );

    // Register the choice; hold the last victim between misses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            victim_vld <= 1'b0;
            victim_way <= '0;
        end else begin
            victim_vld <= miss;
            if (miss) victim_way <= pick;
        end
    end
endmodule

// File: rtl/rp_checker.sv
// Property checker for victim_picker, attached through bind.
// Observes ports plus the stored-MRU read and the random register.
module rp_checker #(
    parameter int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic             req_hit,
    input logic [WAYS-1:0]  way_valid,
    input logic [WAY_W-1:0] mru_rd,
    input logic [15:0]      lfsr_q,
    input logic [WAY_W-1:0] victim_way,
    input logic             victim_vld
);
    logic [WAYS-1:0] mask_q;
    logic [WAYS-1:0] below;

    // Remember the valid bits seen at the previous edge.
    always_ff @(posedge clk) mask_q <= way_valid;

    // Ways below the current victim.
    always_comb below = (WAYS'(1) << victim_way) - WAYS'(1);

    // R9: legal configuration
    initial p_ways_legal_r9: assert (WAYS >= 2 && WAYS <= 16 && (WAYS & (WAYS - 1)) == 0)
        else $error("WAYS must be a power of two from 2 to 16");

    p_vld_after_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_hit) |=> victim_vld);

    p_no_vld_without_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_vld && !req_hit) |=> !victim_vld);

    p_hold_between_misses_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_vld && !req_hit) |=> $stable(victim_way));

    p_empty_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_hit && !(&way_valid)) |=> (!mask_q[victim_way] && ((mask_q & below) == below)));

    p_not_mru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !req_hit && (&way_valid)) |=> victim_way != $past(mru_rd));

    p_rnd_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0000);
endmodule

bind victim_picker rp_checker #(.WAYS(WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_hit    (req_hit),
    .way_valid  (way_valid),
    .mru_rd     (mru_rd),
    .lfsr_q     (lfsr_q),
    .victim_way (victim_way),
    .victim_vld (victim_vld)
);

// File: tb/sim_victim_picker.sv
// Bench: a four-way copy (u0) and a two-way copy (u1) driven alike and compared
// each cycle against a behavioural model.
module sim_victim_picker;
    localparam int CLK_PERIOD = 10;
    localparam int SETS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_vld = 1'b0, req_hit = 1'b0, fill_vld = 1'b0;
    logic [2:0] req_set = '0, fill_set = '0;
    logic [1:0] req_way = '0, fill_way = '0;
    logic [3:0] way_valid = '1;
    logic [1:0] v0_way;
    logic       v0_vld;
    logic [0:0] v1_way;
    logic       v1_vld;

    int compared = 0, mismatched = 0;
    string phase = "R1";

    // model state
    int m_rnd;
    int m_mru0 [SETS];
    int m_mru1 [SETS];
    int e0_way, e1_way, e_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    victim_picker #(.WAYS(4), .SETS(SETS)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_hit(req_hit),
        .req_set(req_set), .req_way(req_way), .way_valid(way_valid),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way),
        .victim_way(v0_way), .victim_vld(v0_vld));

    victim_picker #(.WAYS(2), .SETS(SETS)) u1 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_hit(req_hit),
        .req_set(req_set), .req_way(req_way[0]), .way_valid(way_valid[1:0]),
        .fill_vld(fill_vld), .fill_set(fill_set), .fill_way(fill_way[0]),
        .victim_way(v1_way), .victim_vld(v1_vld));

    function automatic int next_rnd(int s);
        int fb;
        fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
        return ((s << 1) | fb) & 16'hFFFF;
    endfunction

    function automatic int choose(int ways, int mask, int mru, int rnd);
        int r;
        for (int i = 0; i < ways; i++)
            if (((mask >> i) & 1) == 0) return i;
        r = rnd % ways;
        if (r == mru) r = (mru + 1) % ways;
        return r;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(phase, "u0 victim_vld", int'(v0_vld), e_vld);
        check(phase, "u0 victim_way", int'(v0_way), e0_way);
        check("R8", "u1 victim_vld", int'(v1_vld), e_vld);
        check("R8", "u1 victim_way", int'(v1_way), e1_way);
    endtask

    // One cycle: drive at the falling edge, predict, then compare after the rising edge.
    task automatic step(input bit vld, input bit hit, input int set, input int way,
                        input int mask, input bit fv, input int fs, input int fw);
        int n0, n1, nv;
        req_vld = vld; req_hit = hit; req_set = 3'(set); req_way = 2'(way);
        way_valid = 4'(mask); fill_vld = fv; fill_set = 3'(fs); fill_way = 2'(fw);
        n0 = e0_way; n1 = e1_way; nv = 0;
        if (vld && !hit) begin
            nv = 1;
            n0 = choose(4, mask, m_mru0[set], m_rnd);
            n1 = choose(2, mask & 3, m_mru1[set], m_rnd);
        end
        @(posedge clk);
        if (fv) begin m_mru0[fs] = fw; m_mru1[fs] = fw & 1; end
        if (vld && hit) begin m_mru0[set] = way; m_mru1[set] = way & 1; end
        m_rnd = next_rnd(m_rnd);
        e_vld = nv; e0_way = n0; e1_way = n1;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 15, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_rnd = 16'hACE1;
        for (int s = 0; s < SETS; s++) begin m_mru0[s] = 0; m_mru1[s] = 0; end
        e_vld = 0; e0_way = 0; e1_way = 0;
        compare_all();
        rst_n = 1'b1;
        // R1: stored ways start at 0, seen through misses on every set
        for (int s = 0; s < SETS; s++) step(1, 0, s, 0, 15, 0, 0, 0);

        // R2: hits rewrite the recorded way, observed through later misses
        phase = "R2";
        for (int w = 0; w < 4; w++) begin
            step(1, 1, 3, w, 15, 0, 0, 0);
            for (int k = 0; k < 6; k++) step(1, 0, 3, 0, 15, 0, 0, 0);
        end

        // R3: fills, and a fill colliding with a hit on the same set
        phase = "R3";
        step(0, 0, 0, 0, 15, 1, 5, 2);
        for (int k = 0; k < 6; k++) step(1, 0, 5, 0, 15, 0, 0, 0);
        step(1, 1, 5, 3, 15, 1, 5, 1);
        for (int k = 0; k < 6; k++) step(1, 0, 5, 0, 15, 0, 0, 0);
        step(1, 1, 6, 1, 15, 1, 5, 0);
        for (int k = 0; k < 4; k++) begin step(1, 0, 5, 0, 15, 0, 0, 0); step(1, 0, 6, 0, 15, 0, 0, 0); end

        // R4: single misses separated by idle and hit cycles; victim must hold
        phase = "R4";
        for (int k = 0; k < 5; k++) begin
            step(1, 0, k, 0, 15, 0, 0, 0);
            idle();
            step(1, 1, k, 2, 15, 0, 0, 0);
            idle();
        end

        // R5: partly empty sets pick the lowest empty way
        phase = "R5";
        step(1, 0, 1, 0, 4'b1011, 0, 0, 0);
        step(1, 0, 1, 0, 4'b0000, 0, 0, 0);
        step(1, 0, 1, 0, 4'b0111, 0, 0, 0);
        step(1, 0, 1, 0, 4'b1110, 0, 0, 0);
        step(1, 0, 1, 0, 4'b1101, 0, 0, 0);
        step(1, 1, 2, 0, 4'b0111, 0, 0, 0);
        idle();

        // R6: full sets with the recorded way moved around, including way 3 (wrap to 0)
        phase = "R6";
        for (int k = 0; k < 300; k++) begin
            if (k % 3 == 0) step(1, 1, k % SETS, 3, 15, 0, 0, 0);
            step(1, 0, k % SETS, 0, 15, 0, 0, 0);
        end

        // R7: long mixed run; the shift register sequence shows through every victim
        phase = "R7";
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = $urandom_range(0, 9);
            step(r < 8, r < 3, $urandom_range(0, SETS - 1), $urandom_range(0, 3),
                 (r == 7) ? $urandom_range(0, 15) : 15,
                 $urandom_range(0, 3) == 0, $urandom_range(0, SETS - 1), $urandom_range(0, 3));
        end
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule